// File: doc/BRIEF.md
# Byte-Wise CRC-32 Bus Accelerator

This block is a small bus slave that computes the Ethernet CRC-32 of a message supplied one byte per bus write. A processor writes each message byte to an input register. The low eight bits of that write are folded into a 32-bit accumulator in one clock edge by an unrolled XOR network. The accumulator keeps its value between writes, so a message of any length is a plain sequence of writes.

When the message is complete, software reads the raw accumulator from an output register and inverts it to get the standard checksum. The accumulator is preset to all ones at reset. A synchronous clear input presets it again so that a new message can begin. A constant capability output lets system software find out that the accelerator is fitted.

The slave decodes two word-aligned byte addresses: the input register at BASE and the output register at BASE+4. It acknowledges only those two addresses, so another slave can answer every other address.

Top module: `crc32_bus_accel`

## Requirements
- R1: After reset (rst_n low), the accumulator reads back as 0xFFFFFFFF from the output register.
- R2: crc_present is driven to 1 at all times after reset.
- R3: Each write to BASE+0 updates the accumulator with the reflected polynomial 0xEDB88320, taking the byte LSB first. The bitwise inverse of the accumulator then equals standard CRC-32; for example, "123456789" inverts to 0xCBF43926.
- R4: Only bits [7:0] of a write to BASE+0 are used. Bits [31:8] have no effect on the result.
- R5: The accumulator holds its value between writes, so a multi-byte message gives the CRC of the whole byte sequence.
- R6: A read of BASE+4 returns the raw, non-inverted accumulator, and that value already includes a byte written by the access just before it.
- R7: A read of BASE+0 returns 0. A write to BASE+4 leaves the accumulator unchanged.
- R8: An access to BASE+0 or BASE+4 (bus_cyc and bus_stb high) raises bus_ack for exactly one cycle, in the cycle after the strobe is first sampled. bus_rdata is valid while bus_ack is high.
- R9: An access to any other address never raises bus_ack and leaves the accumulator unchanged.
- R10: clr high at a clock edge presets the accumulator to 0xFFFFFFFF. If a byte write lands on the same edge, clr wins: the byte is discarded and the write is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous preset of the accumulator |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data; only [7:0] is used |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge |
| crc_present | output | 1 | Constant capability flag |

## Verification
The two functions that can land on the same edge are the synchronous clear and a byte write to the input register, and the block resolves them in favour of the clear. The bench provokes the overlap by raising clr in the same cycle as a strobed write of a non-trivial byte. It then judges the outcome at the ports: the write must still be acknowledged, and the next read of the output register must return exactly 0xFFFFFFFF rather than the value the byte would have produced.

// File: rtl/crc32_bus_accel.sv
module crc32_bus_accel #(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FE78,
  parameter logic [31:0]     POLY      = 32'hEDB8_8320,
  parameter logic [31:0]     INIT      = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_adr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              crc_present
);

  localparam logic [ADDR_W-1:0] IN_ADR  = BASE_ADDR;
  localparam logic [ADDR_W-1:0] OUT_ADR = BASE_ADDR + ADDR_W'(4);

  function automatic logic [31:0] fold_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] s;
    s = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      s = s[0] ? ((s >> 1) ^ POLY) : (s >> 1);
    return s;
  endfunction

  logic [31:0] acc;
  logic        hit_in, hit_out, req, start;
  logic        unused_hi;

  assign hit_in      = (bus_adr == IN_ADR);
  assign hit_out     = (bus_adr == OUT_ADR);
  assign req         = bus_cyc & bus_stb;
  assign start       = req & (hit_in | hit_out) & ~bus_ack;
  assign crc_present = 1'b1;
  assign unused_hi   = ^bus_wdata[31:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= INIT;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= start;
      bus_rdata <= (start & ~bus_we & hit_out) ? acc : 32'h0;
      if (clr)
        acc <= INIT;
      else if (start & bus_we & hit_in)
        acc <= fold_byte(acc, bus_wdata[7:0]);
    end
  end

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  // R8
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (hit_in || hit_out) && !bus_ack) |=> bus_ack);

  // R9
  unmapped_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hit_in && !hit_out) |=> !bus_ack);

  // R9
  unmapped_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(req && bus_we && hit_in)) |=> $stable(acc));

  // R10
  clear_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == INIT));

  // R7
  in_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !bus_we && hit_in) |=> (bus_ack && bus_rdata == 32'h0));

  // R2
  present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_present);

endmodule

// File: tb/crc32_bus_accel_test.sv
`timescale 1ns/1ps
module crc32_bus_accel_test;
  localparam logic [31:0] BASE = 32'hFFFF_FE78;
  localparam int NV = 6;
  localparam int        VLEN [NV] = '{0, 1, 3, 9, 14, 26};
  localparam logic [207:0] VMSG [NV] = '{
    208'h0, 208'("a"), 208'("abc"), 208'("123456789"),
    208'("message digest"), 208'("abcdefghijklmnopqrstuvwxyz")};
  localparam logic [31:0] VCRC [NV] = '{
    32'h0000_0000, 32'hE8B7_BE43, 32'h3524_41C2, 32'hCBF4_3926,
    32'h2015_9D7F, 32'h4C27_50BD};

  logic clk = 0, rst_n = 0, clr = 0;
  logic cyc = 0, stb = 0, we = 0;
  logic [31:0] adr = 0, wdata = 0, rdata;
  logic ack, present;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  crc32_bus_accel uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bus_cyc(cyc), .bus_stb(stb),
    .bus_we(we), .bus_adr(adr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_ack(ack), .crc_present(present));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdata = d;
    @(negedge clk);
    chk("R8 ack after strobe", {31'h0, ack}, 32'h1);
    r = rdata;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    chk("R8 ack single cycle", {31'h0, ack}, 32'h0);
  endtask

  task automatic clear_acc();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    access(0, BASE + 4, 0, r);
    chk("R1 reset value", r, 32'hFFFF_FFFF);
    chk("R2 capability flag", {31'h0, present}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      clear_acc();
      for (int i = VLEN[v] - 1; i >= 0; i--)
        access(1, BASE, {24'h0, VMSG[v][8*i +: 8]}, r);
      access(0, BASE + 4, 0, r);
      chk("R3 R5 R6 message CRC", ~r, VCRC[v]);
    end

    clear_acc();
    access(1, BASE, 32'h0000_0000, r);
    access(0, BASE + 4, 0, r);
    chk("R3 zero byte", ~r, 32'hD202_EF8D);

    clear_acc();
    access(1, BASE, 32'hABCD_EF61, r);
    access(0, BASE + 4, 0, r);
    chk("R4 upper bits ignored", ~r, 32'hE8B7_BE43);

    access(0, BASE, 0, r);
    chk("R7 input read zero", r, 32'h0);
    access(1, BASE + 4, 32'h1234_5678, r);
    access(0, BASE + 4, 0, r);
    chk("R7 output write no effect", ~r, 32'hE8B7_BE43);

    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = BASE + 8; wdata = 32'h55;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 unmapped no ack", {31'h0, ack}, 32'h0);
    end
    cyc = 0; stb = 0; we = 0;
    access(0, BASE + 4, 0, r);
    chk("R9 unmapped no effect", ~r, 32'hE8B7_BE43);

    clear_acc();
    access(0, BASE + 4, 0, r);
    chk("R10 clear presets", r, 32'hFFFF_FFFF);

    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = BASE; wdata = 32'h61; clr = 1;
    @(negedge clk);
    chk("R10 write acked during clear", {31'h0, ack}, 32'h1);
    cyc = 0; stb = 0; we = 0; clr = 0;
    access(0, BASE + 4, 0, r);
    chk("R10 clear wins over write", r, 32'hFFFF_FFFF);

    access(1, BASE, 32'h31, r);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    access(0, BASE + 4, 0, r);
    chk("R1 reset mid-message", r, 32'hFFFF_FFFF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule